// File: doc/BRIEF.md
# Asynchronous Video Source Resynchronizer

This block takes an 8-bit 4:2:2 luma/chroma byte stream from an outside source that runs on its own clock. It hands the stream to the local pixel-clock domain through a dual-clock FIFO. The source supplies a byte-valid strobe, a line-active level and a frame-active level. Only bytes that are valid inside an active line are stored. The source clock may run at any rate, provided the average number of valid pixels per line matches the programmed active width.

On the local side, a free-running slot counter and line counter set the local raster. When locking is enabled, a rising edge of the source frame-active level snaps both counters to zero at once. The same edge flushes the FIFO, and reading is held back until the FIFO is half full. Horizontal alignment is left to an outside clock synthesizer. Once per local line, the block tells it to speed up, slow down or hold, based on how full the FIFO is.

The block also counts the valid pixels in each source line. It raises a sticky flag when that count is more than two pixels away from the programmed width. It raises separate sticky flags for FIFO overflow and underflow.

Top module: `video_resync`

## Requirements
- R1: Bytes written while `src_valid` and `src_hact` are both high (and the FIFO is not full) leave on `pix_data` in the same order. `pix_de` is high in each cycle that carries one of them.
- R2: `hpos` counts local byte slots from 0 to `htotal`-1, advancing by one on every pixel clock. `vpos` increments each time `hpos` wraps to 0.
- R3: A write attempt while the FIFO holds `DEPTH` (64) bytes drops the byte and sets `err_flags[0]`, which stays set until reset. 64 writes with no reads do not set it.
- R4: With `lock_en` high, a rising edge of `src_vact` brings `hpos` and `vpos` to 0 within six pixel clocks. It also empties the FIFO, and no byte is read until at least `DEPTH`/2 (32) bytes have been written after that edge.
- R5: With `lock_en` low, `src_vact` has no effect on the local raster: `hpos` and `vpos` keep counting as in R2.
- R6: Reads happen only in slots where `hpos` < 2×`hactive`, and only after a locked frame start. Before any locked frame start, `pix_de` stays low whatever the source sends.
- R7: After priming, a read slot that finds the FIFO empty sets `err_flags[1]`, which is sticky.
- R8: At each local line end, `rate_adj` takes a new value: 2'b01 (+1) if the FIFO fill is above `FILL_HI` (48), 2'b11 (−1) if it is below `FILL_LO` (16), and 2'b00 otherwise. It is 2'b00 while unlocked or priming, and it changes only when `hpos` becomes 0.
- R9: For each source line (a high period of `src_hact`), half the number of valid bytes is the pixel count. If that count differs from `hactive` by more than 2, `err_flags[2]` is set and stays set. A difference of exactly 2 does not set it.
- R10: While reset is held, `hpos`, `vpos`, `pix_de`, `rate_adj` and `err_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source byte clock |
| src_rst_n | input | 1 | Synchronous active-low reset, source domain |
| src_valid | input | 1 | Byte on `src_data` is valid |
| src_hact | input | 1 | Source line active level |
| src_vact | input | 1 | Source frame active level; rising edge marks a frame start |
| src_data | input | 8 | Source 4:2:2 byte |
| pix_clk | input | 1 | Local pixel (byte slot) clock |
| pix_rst_n | input | 1 | Synchronous active-low reset, local domain |
| lock_en | input | 1 | Allow source frame starts to realign the local raster |
| hactive | input | 11 | Programmed active pixels per line (static) |
| htotal | input | 12 | Local line length in byte slots (static, at least 2) |
| pix_data | output | 8 | Byte read from the FIFO |
| pix_de | output | 1 | `pix_data` carries a new byte this cycle |
| hpos | output | 12 | Local slot counter |
| vpos | output | 11 | Local line counter |
| rate_adj | output | 2 | Signed rate correction: +1, 0 or −1 |
| err_flags | output | 3 | Sticky flags {width mismatch, underflow, overflow} |

## Verification
The hardest states to reach are the two drift cases: fill pushed past a threshold without first tripping the opposite flag or hitting a wall. To reach them, the bench runs locked streams whose source line period is shorter or longer than the local line, so the fill drifts by two to three bytes per line. It runs enough lines to cross each threshold. A matched-rate run with random byte gaps shows that ordinary jitter leaves the correction at zero. The width tolerance edge is reached by sending lines exactly two pixels off in both directions, and then one pixel further.

// File: rtl/vrs_pkg.sv
// vrs_pkg: types shared by the resynchronizer.
// Assumes: a two-bit signed code is enough for the rate correction.
package vrs_pkg;
    typedef enum logic [1:0] {
        ADJ_NONE = 2'b00,
        ADJ_UP   = 2'b01,
        ADJ_DOWN = 2'b11
    } adj_t;
endpackage

// File: rtl/vrs_ptr_sync.sv
// vrs_ptr_sync: brings a Gray-coded FIFO pointer into another clock domain
// through two flops and returns it in binary.
// Assumes: the source changes the pointer by one Gray step at a time, except
// at a flush, which happens while the far side is idle.
module vrs_ptr_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1, stage2;

    // two-flop synchronizer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the parity of itself and all bits above
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(stage2 >> i);
        end
    end
endmodule

// File: rtl/vrs_dpram.sv
// vrs_dpram: storage for the dual-clock FIFO; write on the source clock,
// read combinationally by address from the local side.
// Assumes: the reader never addresses the slot being written in the same cycle.
module vrs_dpram #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // write port
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/vrs_src_side.sv
// vrs_src_side: source-domain half. Writes valid bytes into the FIFO, flags
// overflow, toggles a frame marker on each rising edge of the frame-active
// level, and checks the pixel count of every line against hactive.
// Assumes: hactive is static; a line is one high period of src_hact.
module vrs_src_side #(
    parameter int AW = 6,
    parameter int HW = 11
) (
    input  logic          src_clk,
    input  logic          src_rst_n,
    input  logic          src_valid,
    input  logic          src_hact,
    input  logic          src_vact,
    input  logic [HW-1:0] hactive,
    input  logic [AW:0]   rd_bin_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wr_gray,
    output logic          vtog,
    output logic          ovf_err,
    output logic          wid_err
);
    localparam int PW = AW + 1;
    localparam int CW = HW + 2;
    localparam int XW = HW + 2;
    localparam logic [XW-1:0] TOL = XW'(2);

    logic [PW-1:0] wr_bin, wr_nxt, used;
    logic          full, wr_req, vact_q, hact_q, line_done, off_width;
    logic [CW-1:0] bcnt;
    logic [XW-1:0] px, ha;

    assign used   = wr_bin - rd_bin_s;
    assign full   = used[AW];
    assign wr_req = src_valid & src_hact;
    assign we     = wr_req & ~full;
    assign wr_nxt = wr_bin + PW'(we);
    assign waddr  = wr_bin[AW-1:0];

    assign line_done = hact_q & ~src_hact;
    assign px        = {1'b0, bcnt[CW-1:1]};
    assign ha        = {2'b00, hactive};
    assign off_width = (px > ha + TOL) || (px + TOL < ha);

    // write pointer and overflow flag
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            ovf_err <= 1'b0;
        end else begin
            wr_bin  <= wr_nxt;
            wr_gray <= wr_nxt ^ (wr_nxt >> 1);
            ovf_err <= ovf_err | (wr_req & full);
        end
    end

    // frame-start marker: toggle on rising edge of vact
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            vact_q <= 1'b0;
            vtog   <= 1'b0;
        end else begin
            vact_q <= src_vact;
            if (src_vact && !vact_q) vtog <= ~vtog;
        end
    end

    // per-line valid byte count and width check
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            hact_q  <= 1'b0;
            bcnt    <= '0;
            wid_err <= 1'b0;
        end else begin
            hact_q <= src_hact;
            if (line_done) begin
                bcnt    <= '0;
                wid_err <= wid_err | off_width;
            end else if (wr_req) begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vrs_pix_side.sv
// vrs_pix_side: local-domain half. Runs the local raster, reads the FIFO in
// active slots, snaps the raster and flushes the FIFO on a locked frame
// start, primes to half depth, and decides the rate correction at line end.
// Assumes: hactive and htotal are static and htotal >= 2.
module vrs_pix_side
    import vrs_pkg::*;
#(
    parameter int AW      = 6,
    parameter int HW      = 11,
    parameter int VW      = 11,
    parameter int DW      = 8,
    parameter int FILL_HI = 48,
    parameter int FILL_LO = 16
) (
    input  logic          pix_clk,
    input  logic          pix_rst_n,
    input  logic          lock_en,
    input  logic [HW-1:0] hactive,
    input  logic [HW:0]   htotal,
    input  logic          vtog_in,
    input  logic [AW:0]   wr_bin_s,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rd_gray,
    output logic [DW-1:0] pix_data,
    output logic          pix_de,
    output logic [HW:0]   hpos,
    output logic [VW-1:0] vpos,
    output logic [1:0]    rate_adj,
    output logic          unf_err
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] HALF_P = PW'(1 << (AW - 1));
    localparam logic [PW-1:0] HI_P   = PW'(FILL_HI);
    localparam logic [PW-1:0] LO_P   = PW'(FILL_LO);

    logic [2:0]    vsync;
    logic          vpulse, snap, started, priming;
    logic          line_end, active, slot_rd, re, empty;
    logic [PW-1:0] rd_bin, rd_nxt, fill;
    logic [HW:0]   hcnt;
    logic [VW-1:0] vcnt;
    adj_t          adj_q, adj_d;

    assign vpulse   = vsync[2] ^ vsync[1];
    assign snap     = lock_en & vpulse;
    assign fill     = wr_bin_s - rd_bin;
    assign empty    = (fill == '0);
    assign line_end = hcnt >= (htotal - 1'b1);
    assign active   = hcnt < {hactive, 1'b0};
    assign slot_rd  = started & ~priming & active;
    assign re       = slot_rd & ~empty;
    assign rd_nxt   = snap ? wr_bin_s : rd_bin + PW'(re);
    assign raddr    = rd_bin[AW-1:0];
    assign hpos     = hcnt;
    assign vpos     = vcnt;
    assign rate_adj = adj_q;

    // synchronize the frame-start toggle
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n) vsync <= '0;
        else            vsync <= {vsync[1:0], vtog_in};
    end

    // local raster counters, snapped on a locked frame start
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (snap || line_end) begin
            hcnt <= '0;
            vcnt <= snap ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // read pointer, flush on lock, priming to half depth
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
            started <= 1'b0;
            priming <= 1'b0;
        end else begin
            rd_bin  <= rd_nxt;
            rd_gray <= rd_nxt ^ (rd_nxt >> 1);
            if (snap) begin
                started <= 1'b1;
                priming <= 1'b1;
            end else if (priming && fill >= HALF_P) begin
                priming <= 1'b0;
            end
        end
    end

    // occupancy-driven correction decision
    always_comb begin
        adj_d = ADJ_NONE;
        if (started && !priming) begin
            if (fill > HI_P)      adj_d = ADJ_UP;
            else if (fill < LO_P) adj_d = ADJ_DOWN;
        end
    end

    // correction register, updated at line end
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n)    adj_q <= ADJ_NONE;
        else if (snap)     adj_q <= ADJ_NONE;
        else if (line_end) adj_q <= adj_d;
    end

    // output byte register and underflow flag
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n) begin
            pix_data <= '0;
            pix_de   <= 1'b0;
            unf_err  <= 1'b0;
        end else begin
            pix_de  <= re;
            if (re) pix_data <= rdata;
            unf_err <= unf_err | (slot_rd & empty);
        end
    end
endmodule

// File: rtl/video_resync.sv
// video_resync: moves a 4:2:2 byte stream from an outside clock into the
// local pixel domain; snaps vertical timing, steers horizontal timing by a
// rate correction, and flags FIFO and line-width faults.
// Assumes: both resets are applied together; hactive and htotal are static.
module video_resync #(
    parameter int DEPTH_LOG2 = 6,
    parameter int HW         = 11,
    parameter int VW         = 11,
    parameter int DW         = 8,
    parameter int FILL_HI    = (3 << DEPTH_LOG2) / 4,
    parameter int FILL_LO    = (1 << DEPTH_LOG2) / 4
) (
    input  logic          src_clk,
    input  logic          src_rst_n,
    input  logic          src_valid,
    input  logic          src_hact,
    input  logic          src_vact,
    input  logic [DW-1:0] src_data,
    input  logic          pix_clk,
    input  logic          pix_rst_n,
    input  logic          lock_en,
    input  logic [HW-1:0] hactive,
    input  logic [HW:0]   htotal,
    output logic [DW-1:0] pix_data,
    output logic          pix_de,
    output logic [HW:0]   hpos,
    output logic [VW-1:0] vpos,
    output logic [1:0]    rate_adj,
    output logic [2:0]    err_flags
);
    localparam int AW = DEPTH_LOG2;
    localparam int PW = AW + 1;

    logic          we, vtog, ovf_raw, wid_raw, unf_err;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wr_gray, rd_gray, wr_bin_s, rd_bin_s;
    logic [DW-1:0] rdata;
    logic [1:0]    ovf_s, wid_s;

    vrs_src_side #(.AW(AW), .HW(HW)) u_src (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
        .src_hact(src_hact), .src_vact(src_vact), .hactive(hactive),
        .rd_bin_s(rd_bin_s), .we(we), .waddr(waddr), .wr_gray(wr_gray),
        .vtog(vtog), .ovf_err(ovf_raw), .wid_err(wid_raw)
    );

    vrs_dpram #(.AW(AW), .DW(DW)) u_mem (
        .wclk(src_clk), .we(we), .waddr(waddr), .wdata(src_data),
        .raddr(raddr), .rdata(rdata)
    );

    vrs_ptr_sync #(.W(PW)) u_wsync (
        .clk(pix_clk), .rst_n(pix_rst_n), .gray_in(wr_gray), .bin_out(wr_bin_s)
    );

    vrs_ptr_sync #(.W(PW)) u_rsync (
        .clk(src_clk), .rst_n(src_rst_n), .gray_in(rd_gray), .bin_out(rd_bin_s)
    );

    vrs_pix_side #(
        .AW(AW), .HW(HW), .VW(VW), .DW(DW), .FILL_HI(FILL_HI), .FILL_LO(FILL_LO)
    ) u_pix (
        .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .lock_en(lock_en),
        .hactive(hactive), .htotal(htotal), .vtog_in(vtog), .wr_bin_s(wr_bin_s),
        .rdata(rdata), .raddr(raddr), .rd_gray(rd_gray), .pix_data(pix_data),
        .pix_de(pix_de), .hpos(hpos), .vpos(vpos), .rate_adj(rate_adj),
        .unf_err(unf_err)
    );

    // bring the source-domain sticky flags into the pixel domain
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n) begin
            ovf_s <= '0;
            wid_s <= '0;
        end else begin
            ovf_s <= {ovf_s[0], ovf_raw};
            wid_s <= {wid_s[0], wid_raw};
        end
    end

    assign err_flags = {wid_s[1], unf_err, ovf_s[1]};
endmodule

// File: rtl/vrs_checker.sv
// vrs_checker: temporal properties on the pixel-side ports of video_resync.
// Assumes: hactive is static during a run.
module vrs_checker #(
    parameter int HW = 11
) (
    input logic          pix_clk,
    input logic          pix_rst_n,
    input logic          pix_de,
    input logic [HW:0]   hpos,
    input logic [HW-1:0] hactive,
    input logic [1:0]    rate_adj,
    input logic [2:0]    err_flags
);
    // nonzero slot positions only come from a one-step advance
    assert_hpos_step_R2: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        (hpos != '0) |-> (hpos == $past(hpos) + 1'b1));

    // a byte appears only after a read in an active slot
    assert_read_slot_R6: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        pix_de |-> ($past(hpos) < {$past(hactive), 1'b0}));

    // correction moves only at the start of a local line
    assert_adj_at_line_R8: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        !$stable(rate_adj) |-> (hpos == '0));

    assert_ovf_sticky_R3: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        err_flags[0] |=> err_flags[0]);

    assert_unf_sticky_R7: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        err_flags[1] |=> err_flags[1]);

    assert_wid_sticky_R9: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        err_flags[2] |=> err_flags[2]);
endmodule

bind video_resync vrs_checker #(.HW(HW)) u_chk (
    .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .pix_de(pix_de), .hpos(hpos),
    .hactive(hactive), .rate_adj(rate_adj), .err_flags(err_flags)
);

// File: tb/video_resync_tb.sv
`timescale 1ns/1ps
module video_resync_tb;
    logic        src_clk = 1'b0, pix_clk = 1'b0;
    logic        src_rst_n, pix_rst_n, src_valid, src_hact, src_vact, lock_en;
    logic [7:0]  src_data;
    logic [10:0] hactive;
    logic [11:0] htotal;
    logic [7:0]  pix_data;
    logic        pix_de;
    logic [11:0] hpos;
    logic [10:0] vpos;
    logic [1:0]  rate_adj;
    logic [2:0]  err_flags;

    int n_chk = 0, n_fail = 0, n_wr = 0, de_cnt = 0, first_de_wr = -1;
    int seen_up = 0, seen_down = 0, rate_bad = 0;
    bit sb_on = 0, rate_mon = 0, done = 0;
    logic [7:0] sbq[$];
    logic [7:0] exp_b;

    always #4 pix_clk = ~pix_clk;
    always #3 src_clk = ~src_clk;

    video_resync u_dut (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
        .src_hact(src_hact), .src_vact(src_vact), .src_data(src_data),
        .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .lock_en(lock_en),
        .hactive(hactive), .htotal(htotal), .pix_data(pix_data), .pix_de(pix_de),
        .hpos(hpos), .vpos(vpos), .rate_adj(rate_adj), .err_flags(err_flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [11:0] exp_h(input int h0, input int steps, input int tot);
        return 12'((h0 + steps) % tot);
    endfunction

    function automatic logic [10:0] exp_v(input int v0, input int h0, input int steps, input int tot);
        return 11'(v0 + (h0 + steps) / tot);
    endfunction

    task automatic do_reset();
        src_valid = 0; src_hact = 0; src_vact = 0; lock_en = 0; src_data = 0;
        pix_rst_n = 0; src_rst_n = 0;
        sb_on = 0; rate_mon = 0; sbq.delete();
        repeat (5) @(negedge pix_clk);
        pix_rst_n = 1; src_rst_n = 1;
        n_wr = 0; de_cnt = 0; first_de_wr = -1; seen_up = 0; seen_down = 0; rate_bad = 0;
    endtask

    // one source line: hact high for period-4 cycles, nbytes valid at random spots
    task automatic src_line(input int period, input int nbytes, input bit track);
        int left = nbytes;
        for (int c = 0; c < period; c++) begin
            @(posedge src_clk); #1;
            if (c < period - 4) begin
                src_hact = 1;
                if (left > 0 && ((period - 4 - c) <= left || ($urandom % 2) == 1)) begin
                    src_valid = 1;
                    src_data  = 8'($urandom);
                    if (track) sbq.push_back(src_data);
                    n_wr++;
                    left--;
                end else begin
                    src_valid = 0;
                end
            end else begin
                src_hact = 0; src_valid = 0;
            end
        end
    endtask

    task automatic src_burst(input int n);
        for (int c = 0; c < n; c++) begin
            @(posedge src_clk); #1;
            src_hact = 1; src_valid = 1; src_data = 8'($urandom); n_wr++;
        end
        @(posedge src_clk); #1;
        src_valid = 0;
    endtask

    task automatic frame_start();
        repeat (2) @(posedge src_clk); #1;
        src_vact = 1;
        repeat (10) @(posedge src_clk);
        n_wr = 0; first_de_wr = -1;
    endtask

    // output monitor, sampled away from the active edge
    always @(negedge pix_clk) begin
        if (pix_rst_n) begin
            if (pix_de) begin
                de_cnt++;
                if (first_de_wr < 0) first_de_wr = n_wr;
                if (sb_on) begin
                    if (sbq.size() == 0) begin
                        chk("R1 unexpected byte", 1, 0);
                    end else begin
                        exp_b = sbq.pop_front();
                        chk("R1 byte order", pix_data, exp_b);
                    end
                end
            end
            if (hpos == 0) begin
                if (rate_adj == 2'b01) seen_up++;
                if (rate_adj == 2'b11) seen_down++;
                if (rate_mon && rate_adj != 2'b00) rate_bad++;
            end
        end
    end

    initial begin
        int h0, v0;
        void'($urandom(32'd860));
        hactive = 11'd8; htotal = 12'd24;

        // P1: reset state and free-running raster
        do_reset();
        pix_rst_n = 0; src_rst_n = 0;
        repeat (3) @(negedge pix_clk);
        chk("R10 hpos", hpos, 0);
        chk("R10 vpos", vpos, 0);
        chk("R10 de", pix_de, 0);
        chk("R10 rate", rate_adj, 0);
        chk("R10 err", err_flags, 0);
        pix_rst_n = 1; src_rst_n = 1;
        repeat (30) @(negedge pix_clk);
        chk("R2 hpos", hpos, exp_h(0, 30, 24));
        chk("R2 vpos", vpos, exp_v(0, 0, 30, 24));

        // P2: unlocked, vact ignored, nothing read
        do_reset();
        repeat (10) @(negedge pix_clk);
        h0 = hpos; v0 = vpos;
        fork
            repeat (20) @(negedge pix_clk);
            begin repeat (3) @(posedge src_clk); #1; src_vact = 1; end
        join
        chk("R5 hpos continues", hpos, exp_h(h0, 20, 24));
        chk("R5 vpos continues", vpos, exp_v(v0, h0, 20, 24));
        src_line(32, 16, 0);
        src_line(32, 16, 0);
        repeat (20) @(negedge pix_clk);
        chk("R6 no read unlocked", de_cnt, 0);
        chk("R8 no adj unlocked", rate_adj, 0);

        // P3: locked, matched rate, random gaps
        do_reset();
        lock_en = 1; sb_on = 1;
        repeat (60) @(negedge pix_clk);
        chk("R2 vpos before snap", vpos, 2);
        @(posedge src_clk); #1; src_vact = 1;
        repeat (8) @(negedge pix_clk);
        chk("R4 vpos snapped", vpos, 0);
        chk("R4 hpos snapped", (hpos <= 6) ? 1 : 0, 1);
        repeat (8) @(posedge src_clk);
        n_wr = 0; first_de_wr = -1;
        for (int l = 0; l < 20; l++) begin
            if (l == 6) rate_mon = 1;
            src_line(32, 16, 1);
        end
        rate_mon = 0;
        chk("R4 primed to half", (first_de_wr >= 32) ? 1 : 0, 1);
        chk("R1 bytes delivered", (de_cnt >= 250) ? 1 : 0, 1);
        chk("R8 hold at matched rate", rate_bad, 0);
        chk("R3 R7 R9 no errors", err_flags, 0);
        sb_on = 0;

        // P4: source faster, fill climbs
        do_reset();
        lock_en = 1;
        frame_start();
        for (int l = 0; l < 14; l++) src_line(28, 16, 0);
        chk("R8 speed-up seen", (seen_up > 0) ? 1 : 0, 1);
        chk("R8 no slow-down when fast", seen_down, 0);

        // P5: source slower, fill drains
        do_reset();
        lock_en = 1;
        frame_start();
        for (int l = 0; l < 14; l++) src_line(38, 16, 0);
        chk("R8 slow-down seen", (seen_down > 0) ? 1 : 0, 1);
        chk("R8 no speed-up when slow", seen_up, 0);

        // P6: underflow after the source stops
        do_reset();
        lock_en = 1;
        frame_start();
        for (int l = 0; l < 4; l++) src_line(32, 16, 0);
        chk("R7 clean before stall", err_flags, 0);
        repeat (200) @(negedge pix_clk);
        chk("R7 underflow flagged", err_flags, 3'b010);

        // P7: width tolerance
        do_reset();
        src_line(32, 20, 0);
        repeat (10) @(negedge pix_clk);
        chk("R9 plus two tolerated", err_flags[2], 0);
        src_line(32, 12, 0);
        repeat (10) @(negedge pix_clk);
        chk("R9 minus two tolerated", err_flags[2], 0);
        src_line(32, 22, 0);
        repeat (10) @(negedge pix_clk);
        chk("R9 plus three flagged", err_flags[2], 1);
        repeat (10) @(negedge pix_clk);
        chk("R9 flag sticky", err_flags[2], 1);
        do_reset();
        src_line(32, 10, 0);
        repeat (10) @(negedge pix_clk);
        chk("R9 minus three flagged", err_flags[2], 1);

        // P8: overflow at exactly one past full
        do_reset();
        src_burst(64);
        repeat (10) @(negedge pix_clk);
        chk("R3 full not overflow", err_flags[0], 0);
        src_burst(1);
        repeat (10) @(negedge pix_clk);
        chk("R3 overflow flagged", err_flags[0], 1);
        chk("R6 no read unlocked", de_cnt, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule